// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of a single memory burst, one per clock. A controller pulses `start` with the first column, a burst length code and an ordering select. On every following clock the block presents the next column of the burst until the burst is complete or `stop` cuts it short. The final beat of a fixed-length burst is marked by `last_beat`.

Two orderings are available. Sequential ordering counts upward inside a block of columns that is aligned to the burst length and wraps inside that block. Interleaved ordering XORs the beat number into the low column bits. A full-page length counts through the whole column space, wraps at its end, and only finishes when `stop` is given. Interleaved ordering is not defined for full page. If it is requested, the block raises `order_err` and runs the burst in sequential order instead. Issuing commands, moving data and checking timing are left to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `col_valid`, `last_beat` and `order_err` are 0 and `col_addr` is 0.
- R2: When `start` is sampled high, the next cycle shows `col_valid`=1 and `col_addr` equal to the sampled `start_col`. This is beat 0.
- R3: `bl_code` selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give 1 beat.
- R4: With `interleave`=0 and a fixed length BL, the low log2(BL) bits of beat n equal (start low bits + n) mod BL. All higher column bits stay equal to `start_col`.
- R5: With `interleave`=1 and a fixed length BL, beat n equals `start_col` with its low log2(BL) bits XORed with n.
- R6: In full page, each beat's address is the previous address plus one, modulo 2^COL_W. `last_beat` stays 0 and the burst continues until `stop` or a new `start`.
- R7: `interleave`=1 together with code 3'b111 sets `order_err` from beat 0 to the end of that burst, and the ordering is sequential. In every other case `order_err` is 0.
- R8: `last_beat` is 1 exactly in the cycle that shows the final address of a fixed-length burst. In the next cycle `col_valid` is 0 unless a new `start` was sampled.
- R9: If `stop` is sampled high while a burst is active and `start` is low, `col_valid` is 0 in the next cycle. A `stop` sampled while idle has no effect.
- R10: A `start` sampled during an active burst begins the new burst at once, and it takes priority over a `stop` sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst with the values sampled this cycle |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved ordering, 0 selects sequential |
| stop | input | 1 | Terminate the running burst |
| col_valid | output | 1 | `col_addr` holds a beat of the burst |
| col_addr | output | COL_W | Column address of the current beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| order_err | output | 1 | Interleaved full-page request, run as sequential |

## Verification
Fixed-length bursts are started at columns whose low bits are zero, mid-block and all ones. This separates a wrap kept inside the aligned block from a carry into the upper bits, and it separates the XOR ordering from the additive one. Full-page bursts start a few columns below the top of the space and run across the wrap, in both orderings, so the error fallback can be seen. Stop and restart are placed before, on and after the final beat, and the reserved length codes are included. A long run of random bursts with random stops catches interactions that the directed cases do not reach.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {
    BLC_ONE  = 3'b000,
    BLC_TWO  = 3'b001,
    BLC_FOUR = 3'b010,
    BLC_EIGHT= 3'b011,
    BLC_PAGE = 3'b111
  } blen_code_e;

  localparam int BLC_W = 3;
endpackage

// File: rtl/blen_decode.sv
module blen_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [BLC_W-1:0] code,
  input  logic             want_inter,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page_mode,
  output logic             use_inter,
  output logic             bad_order
);
  always_comb begin
    wrap_mask = '0;
    page_mode = 1'b0;
    case (blen_code_e'(code))
      BLC_ONE:   wrap_mask = COL_W'(0);
      BLC_TWO:   wrap_mask = COL_W'(1);
      BLC_FOUR:  wrap_mask = COL_W'(3);
      BLC_EIGHT: wrap_mask = COL_W'(7);
      BLC_PAGE: begin
        wrap_mask = '1;
        page_mode = 1'b1;
      end
      default:   wrap_mask = COL_W'(0);
    endcase
    bad_order = want_inter & page_mode;
    use_inter = want_inter & ~page_mode;
  end
endmodule

// File: rtl/col_calc.sv
module col_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             use_inter,
  input  logic [COL_W-1:0] beat_idx,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] summed;
  assign summed = base + beat_idx;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!wrap_mask[b])
        addr[b] = base[b];
      else if (use_inter)
        addr[b] = base[b] ^ beat_idx[b];
      else
        addr[b] = summed[b];
    end
  end
endmodule

// File: rtl/beat_ctl.sv
module beat_ctl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] ld_mask,
  input  logic             ld_page,
  output logic             run_q,
  output logic             run_nxt,
  output logic             fin_q,
  output logic [COL_W-1:0] idx_nxt,
  output logic [COL_W-1:0] mask_sel
);
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic             page_sel;
  logic             fin_nxt;

  always_comb begin
    mask_sel = start ? ld_mask : mask_q;
    page_sel = start ? ld_page : page_q;
    idx_nxt  = start ? '0 : beat_q + 1'b1;
    run_nxt  = start | (run_q & ~stop & ~fin_q);
    fin_nxt  = run_nxt & ~page_sel & (idx_nxt == mask_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
      beat_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
    end else begin
      run_q <= run_nxt;
      fin_q <= fin_nxt;
      if (run_nxt) beat_q <= idx_nxt;
      if (start) begin
        mask_q <= ld_mask;
        page_q <= ld_page;
      end
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             last_beat,
  output logic             order_err
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page, dec_inter, dec_bad;
  logic             run_q, run_nxt, fin_q;
  logic [COL_W-1:0] idx_nxt, mask_sel;
  logic [COL_W-1:0] base_q, base_sel, addr_nxt, addr_q;
  logic             inter_q, inter_sel, err_q;

  blen_decode #(.COL_W(COL_W)) u_dec (
    .code(bl_code), .want_inter(interleave),
    .wrap_mask(dec_mask), .page_mode(dec_page),
    .use_inter(dec_inter), .bad_order(dec_bad)
  );

  beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .ld_mask(dec_mask), .ld_page(dec_page),
    .run_q(run_q), .run_nxt(run_nxt), .fin_q(fin_q),
    .idx_nxt(idx_nxt), .mask_sel(mask_sel)
  );

  assign base_sel  = start ? start_col : base_q;
  assign inter_sel = start ? dec_inter : inter_q;

  col_calc #(.COL_W(COL_W)) u_calc (
    .base(base_sel), .wrap_mask(mask_sel), .use_inter(inter_sel),
    .beat_idx(idx_nxt), .addr(addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      inter_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (start) begin
        base_q  <= start_col;
        inter_q <= dec_inter;
      end
      err_q <= start ? dec_bad : (run_nxt & err_q);
      if (run_nxt) addr_q <= addr_nxt;
    end
  end

  assign col_valid = run_q;
  assign col_addr  = addr_q;
  assign last_beat = fin_q;
  assign order_err = err_q;
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_code,
  input logic             interleave,
  input logic             stop,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             last_beat,
  input logic             order_err
);
  logic page_run;
  always_ff @(posedge clk) begin
    if (rst) page_run <= 1'b0;
    else if (start) page_run <= (bl_code == 3'b111);
  end

  p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> col_valid && col_addr == $past(start_col));
  p_page_step_r6: assert property (@(posedge clk) disable iff (rst)
    col_valid && page_run && !stop && !start |=> col_addr == COL_W'($past(col_addr) + 1'b1));
  p_page_no_last_r6: assert property (@(posedge clk) disable iff (rst)
    col_valid && page_run |-> !last_beat);
  p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
    start && interleave && bl_code == 3'b111 |=> order_err);
  p_err_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
    order_err |-> col_valid);
  p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> col_valid);
  p_end_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    last_beat && !start |=> !col_valid);
  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    col_valid && stop && !start |=> !col_valid);
endmodule

bind burst_col_seq burst_col_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst, start, interleave, stop;
  logic [CW-1:0] start_col;
  logic [2:0] bl_code;
  logic col_valid, last_beat, order_err;
  logic [CW-1:0] col_addr;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  burst_col_seq #(.COL_W(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .bl_code(bl_code), .interleave(interleave), .stop(stop),
    .col_valid(col_valid), .col_addr(col_addr),
    .last_beat(last_beat), .order_err(order_err)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int m_valid = 0, m_last = 0, m_err = 0, m_addr = 0;
  int m_len = 1, m_n = 0, m_base = 0, m_inter = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_last = 0; m_err = 0; m_addr = 0;
    end else begin
      if (start) begin
        case (bl_code)
          3'd1: m_len = 2;
          3'd2: m_len = 4;
          3'd3: m_len = 8;
          3'd7: m_len = 0;
          default: m_len = 1;
        endcase
        m_base = start_col;
        m_inter = (interleave && m_len != 0) ? 1 : 0;
        m_err = (interleave && m_len == 0) ? 1 : 0;
        m_n = 0;
        m_valid = 1;
      end else if (m_valid != 0 && !stop && m_last == 0) begin
        m_n = m_n + 1;
      end else begin
        m_valid = 0;
        m_err = 0;
      end
      if (m_valid != 0) begin
        if (m_len == 0) m_addr = (m_base + m_n) % 256;
        else if (m_inter != 0) m_addr = m_base ^ m_n;
        else m_addr = m_base - (m_base % m_len) + ((m_base % m_len) + m_n) % m_len;
        m_last = (m_len != 0 && m_n == m_len - 1) ? 1 : 0;
      end else begin
        m_last = 0;
      end
    end
  end

  task automatic check_eq(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check_eq(tag, "col_valid", int'(col_valid), m_valid);
      check_eq(tag, "last_beat", int'(last_beat), m_last);
      check_eq(tag, "order_err", int'(order_err), m_err);
      check_eq(tag, "col_addr", int'(col_addr), m_addr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go(input int col, input int code, input int inter);
    @(negedge clk);
    start = 1'b1; start_col = CW'(col); bl_code = 3'(code); interleave = inter[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; stop = 1'b0; interleave = 1'b0;
    start_col = '0; bl_code = '0;
    idle(3);
    // R1: reset state
    check_eq("R1", "col_valid", int'(col_valid), 0);
    check_eq("R1", "last_beat", int'(last_beat), 0);
    check_eq("R1", "order_err", int'(order_err), 0);
    check_eq("R1", "col_addr", int'(col_addr), 0);
    rst = 1'b0;

    // R4: directed sequential BL4 from 0x35
    tag = "R4";
    go('h35, 2, 0);
    check_eq("R4", "beat0", int'(col_addr), 'h35); idle(1);
    check_eq("R4", "beat1", int'(col_addr), 'h36); idle(1);
    check_eq("R4", "beat2", int'(col_addr), 'h37); idle(1);
    check_eq("R4", "beat3", int'(col_addr), 'h34);
    check_eq("R8", "last", int'(last_beat), 1); idle(1);
    check_eq("R8", "drop", int'(col_valid), 0);
    idle(2);

    // R5: directed interleaved BL8 from 0x35
    tag = "R5";
    go('h35, 3, 1);
    begin
      int exp_seq[8] = '{'h35, 'h34, 'h37, 'h36, 'h31, 'h30, 'h33, 'h32};
      for (int i = 0; i < 8; i++) begin
        check_eq("R5", "beat", int'(col_addr), exp_seq[i]);
        if (i < 7) idle(1);
      end
    end
    idle(3);

    // R2 R3 R4 R5: every code, both orderings, several starts
    tag = "R3";
    for (int c = 0; c < 8; c++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 3; s++) begin
          if (c == 7) continue;
          go(s == 0 ? 'h40 : (s == 1 ? 'h5B : 'hFF), c, o);
          idle(9);
        end

    // R6 R7: full page across the wrap, then stop
    tag = "R6";
    go('hFA, 7, 0);
    idle(270);
    check_eq("R6", "still_valid", int'(col_valid), 1);
    stop = 1'b1; idle(1); stop = 1'b0;
    check_eq("R9", "stopped", int'(col_valid), 0);
    idle(2);
    tag = "R7";
    go('hFC, 7, 1);
    check_eq("R7", "err_flag", int'(order_err), 1);
    idle(10);
    stop = 1'b1; idle(1); stop = 1'b0;
    check_eq("R7", "err_clear", int'(order_err), 0);
    idle(2);

    // R9: stop mid burst, stop while idle
    tag = "R9";
    go('h10, 3, 0); idle(2);
    stop = 1'b1; idle(1); stop = 1'b0;
    idle(3);
    stop = 1'b1; idle(2); stop = 1'b0;
    check_eq("R9", "idle_stop", int'(col_valid), 0);

    // R10: restart during burst, start with stop
    tag = "R10";
    go('h20, 3, 0); idle(2);
    go('h81, 2, 1); idle(1);
    @(negedge clk); start = 1'b1; stop = 1'b1; start_col = 'hC7; bl_code = 3'd3; interleave = 1'b0;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    check_eq("R10", "restart_addr", int'(col_addr), 'hC7);
    idle(10);

    // random mix of everything
    tag = "R8";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      start = ($urandom_range(0, 5) == 0);
      stop = ($urandom_range(0, 11) == 0);
      start_col = CW'($urandom_range(0, 255));
      bl_code = 3'($urandom_range(0, 7));
      interleave = 1'($urandom_range(0, 1));
    end
    start = 1'b0; stop = 1'b1; idle(2); stop = 1'b0;
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule